// File: doc/BRIEF.md
# Dual-Mode Recovery Arbiter

This block decides whether a serial configuration memory is streaming its contents on a free-running display clock (stream mode) or is serving a two-wire I2C master. It watches two asynchronous pins: the stream clock, here `vclk_i`, and the I2C clock, `scl_i`. It also watches a one-cycle pulse from the I2C slave logic. That pulse reports that a START was followed by a matching device select byte. The block reports the current mode and pulses a clear for the stream-mode byte pointer whenever streaming restarts.

A falling edge on the I2C clock does not commit the block to I2C operation. It first enters a probation state, which the rest of the chip treats as I2C mode. The block leaves probation and goes back to streaming in two cases: when a fixed number of stream-clock pulses has arrived, or when a timeout measured in system clock cycles has expired, in each case with no device select matched. Every further I2C clock falling edge restarts both measurements. A matched device select during probation locks the block into I2C mode for good. A build-time option selects a stricter variant in which the first I2C clock falling edge locks at once. In that variant only a reset brings back streaming.

Both pins pass through a synchroniser chain before edge detection. Every decision is made in the system clock domain.

Top module: `recovery_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` reads 0 (stream) and `ptr_rst_o` is 1. On the first clock edge after reset is released with no I2C clock activity, `ptr_rst_o` drops to 0.
- R2: In stream mode (code 0), only a synchronised falling edge of `scl_i` changes the mode. Stream clock pulses and `sel_match_i` pulses leave it at 0. With the default locking option off, the falling edge moves the mode to probation (code 1).
- R3: In probation, the `PULSE_LIMIT`-th rising edge of `vclk_i` since entry or since the last restart returns the mode to 0, provided no device select arrived in between.
- R4: In probation, the mode returns to 0 once `TIMEOUT_CYCLES` system clock cycles have passed since entry or since the last restart, provided no device select arrived in between.
- R5: In probation, each falling edge of `scl_i` clears both the pulse count and the elapsed time, and the mode stays 1.
- R6: In probation, a `sel_match_i` pulse moves the mode to locked (code 2). The locked mode then ignores `vclk_i`, `scl_i` and any time that passes.
- R7: With `LOCK_ON_FIRST` set, the first falling edge of `scl_i` moves the mode straight from 0 to 2, code 1 never appears, and only reset returns the mode to 0.
- R8: `ptr_rst_o` is high for exactly one cycle after each return from probation to stream mode, and is high only while the mode is 0.
- R9: `i2c_mode_o` is high exactly when `mode_o` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vclk_i | input | 1 | Stream clock pin, asynchronous |
| scl_i | input | 1 | I2C clock pin, asynchronous |
| sel_match_i | input | 1 | One-cycle pulse: START plus matching device select seen |
| mode_o | output | 2 | 0 stream, 1 probation, 2 locked |
| i2c_mode_o | output | 1 | High in probation or locked |
| ptr_rst_o | output | 1 | Clear for the stream byte pointer |

## Verification
The bench builds two copies side by side. One uses a pulse limit of 128 and a timeout of 2000 cycles with locking off; the other uses the same limits with `LOCK_ON_FIRST` set. At these values the full 128-pulse escape, a restarted timer that outlives its original deadline, and a genuine timeout all fit within a few thousand cycles. Driving both copies from the same pins shows how the two variants diverge on the same I2C clock edge.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef enum logic [1:0] {
    MODE_STREAM = 2'd0,
    MODE_PROBE  = 2'd1,
    MODE_LOCKED = 2'd2
  } mode_e;
endpackage

// File: rtl/rmc_edge_sync.sv
module rmc_edge_sync #(
  parameter int STAGES      = 2,
  parameter bit DETECT_FALL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], d_i};
  end

  generate
    if (DETECT_FALL) begin : g_fall
      assign edge_o = sr_q[STAGES] & ~sr_q[STAGES-1];
    end else begin : g_rise
      assign edge_o = ~sr_q[STAGES] & sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rmc_window_cnt.sv
module rmc_window_cnt #(
  parameter int LIMIT = 128,
  localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic          hit_o,
  output logic [CW-1:0] cnt_o
);
  assign hit_o = inc_i && (cnt_o == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= hit_o ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/recovery_mode_ctrl.sv
module recovery_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int PULSE_LIMIT    = 128,
  parameter int TIMEOUT_CYCLES = 250_000_000,
  parameter bit LOCK_ON_FIRST  = 1'b0,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vclk_i,
  input  logic       scl_i,
  input  logic       sel_match_i,
  output logic [1:0] mode_o,
  output logic       i2c_mode_o,
  output logic       ptr_rst_o
);
  localparam int PCW = (PULSE_LIMIT > 2) ? $clog2(PULSE_LIMIT) : 1;
  localparam int TCW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam mode_e ENTRY_MODE = LOCK_ON_FIRST ? MODE_LOCKED : MODE_PROBE;

  mode_e          state_q, state_d;
  logic           ptr_q;
  logic           vclk_rise, scl_fall;
  logic           in_probe, win_clr;
  logic           pulse_hit, time_hit;
  logic [PCW-1:0] pulse_cnt;
  logic [TCW-1:0] time_cnt;

  rmc_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b0)) u_vclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vclk_i), .edge_o(vclk_rise));

  rmc_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b1)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .edge_o(scl_fall));

  assign in_probe = (state_q == MODE_PROBE);
  // counters run only in probation; any SCL fall restarts both
  assign win_clr  = !in_probe || scl_fall;

  rmc_window_cnt #(.LIMIT(PULSE_LIMIT)) u_pulse_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(win_clr),
    .inc_i(in_probe && vclk_rise), .hit_o(pulse_hit), .cnt_o(pulse_cnt));

  rmc_window_cnt #(.LIMIT(TIMEOUT_CYCLES)) u_time_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(win_clr),
    .inc_i(in_probe), .hit_o(time_hit), .cnt_o(time_cnt));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_STREAM: if (scl_fall) state_d = ENTRY_MODE;
      MODE_PROBE: begin
        if (sel_match_i)                state_d = MODE_LOCKED;
        else if (scl_fall)              state_d = MODE_PROBE;
        else if (pulse_hit || time_hit) state_d = MODE_STREAM;
      end
      MODE_LOCKED: state_d = MODE_LOCKED;
      default:     state_d = MODE_STREAM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_STREAM;
      ptr_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      ptr_q   <= (state_d == MODE_STREAM) && (state_q != MODE_STREAM);
    end
  end

  assign mode_o     = state_q;
  assign i2c_mode_o = (state_q != MODE_STREAM);
  assign ptr_rst_o  = ptr_q;
endmodule

// File: rtl/rmc_checker.sv
module rmc_checker
  import rmc_pkg::*;
#(
  parameter int PULSE_LIMIT    = 128,
  parameter int TIMEOUT_CYCLES = 250_000_000,
  parameter bit LOCK_ON_FIRST  = 1'b0,
  localparam int PCW = (PULSE_LIMIT > 2) ? $clog2(PULSE_LIMIT) : 1,
  localparam int TCW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     mode_o,
  input logic           i2c_mode_o,
  input logic           ptr_rst_o,
  input logic           sel_match_i,
  input logic           scl_fall,
  input logic           vclk_rise,
  input logic [PCW-1:0] pulse_cnt,
  input logic [TCW-1:0] time_cnt
);
  AST_STREAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STREAM && !scl_fall) |=> (mode_o == MODE_STREAM)); // R2

  AST_PULSE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROBE && !sel_match_i && !scl_fall && vclk_rise &&
     pulse_cnt == PCW'(PULSE_LIMIT - 1)) |=> (mode_o == MODE_STREAM)); // R3

  AST_TIMER_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROBE && !sel_match_i && !scl_fall &&
     time_cnt == TCW'(TIMEOUT_CYCLES - 1)) |=> (mode_o == MODE_STREAM)); // R4

  AST_SCL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROBE && scl_fall && !sel_match_i)
      |=> (mode_o == MODE_PROBE && pulse_cnt == '0 && time_cnt == '0)); // R5

  AST_SEL_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROBE && sel_match_i) |=> (mode_o == MODE_LOCKED)); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_LOCKED) |=> (mode_o == MODE_LOCKED)); // R6

  AST_NO_PROBE_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LOCK_ON_FIRST |-> (mode_o != MODE_PROBE)); // R7

  AST_PTR_ONLY_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_o |-> (mode_o == MODE_STREAM)); // R8

  AST_PTR_ON_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROBE) ##1 (mode_o == MODE_STREAM) |-> ptr_rst_o); // R8

  AST_I2C_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2c_mode_o == (mode_o != MODE_STREAM)); // R9
endmodule

bind recovery_mode_ctrl rmc_checker #(
  .PULSE_LIMIT(PULSE_LIMIT), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .LOCK_ON_FIRST(LOCK_ON_FIRST)
) u_rmc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .i2c_mode_o(i2c_mode_o),
  .ptr_rst_o(ptr_rst_o), .sel_match_i(sel_match_i), .scl_fall(scl_fall),
  .vclk_rise(vclk_rise), .pulse_cnt(pulse_cnt), .time_cnt(time_cnt)
);

// File: tb/recovery_mode_ctrl_bench.sv
module recovery_mode_ctrl_bench;
  localparam int PL = 128;
  localparam int TO = 2000;

  logic clk = 1'b0, rst_n = 1'b0, vclk = 1'b0, scl = 1'b1, sel = 1'b0;
  logic [1:0] mode [2];
  logic       i2c [2];
  logic       ptr [2];
  int checks = 0, failures = 0, ptr_pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  recovery_mode_ctrl #(.PULSE_LIMIT(PL), .TIMEOUT_CYCLES(TO), .LOCK_ON_FIRST(1'b0)) u_recovery_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .vclk_i(vclk), .scl_i(scl), .sel_match_i(sel),
    .mode_o(mode[0]), .i2c_mode_o(i2c[0]), .ptr_rst_o(ptr[0]));

  recovery_mode_ctrl #(.PULSE_LIMIT(PL), .TIMEOUT_CYCLES(TO), .LOCK_ON_FIRST(1'b1)) u_recovery_mode_ctrl_lock (
    .clk_i(clk), .rst_ni(rst_n), .vclk_i(vclk), .scl_i(scl), .sel_match_i(sel),
    .mode_o(mode[1]), .i2c_mode_o(i2c[1]), .ptr_rst_o(ptr[1]));

  // reference model: pin history queues, two sync stages plus edge flop
  bit qs[$], qv[$];
  int m_mode [2], m_pc [2], m_tc [2];
  bit m_ptr [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qs = '{1'b0, 1'b0, 1'b0};
      qv = '{1'b0, 1'b0, 1'b0};
      for (int v = 0; v < 2; v++) begin
        m_mode[v] = 0; m_pc[v] = 0; m_tc[v] = 0; m_ptr[v] = 1'b1;
      end
    end else begin
      bit fall, rise;
      qs.push_back(scl);
      qv.push_back(vclk);
      fall = qs[0] && !qs[1];
      rise = qv[1] && !qv[0];
      void'(qs.pop_front());
      void'(qv.pop_front());
      for (int v = 0; v < 2; v++) begin
        m_ptr[v] = 1'b0;
        case (m_mode[v])
          0: if (fall) begin m_mode[v] = (v == 1) ? 2 : 1; m_pc[v] = 0; m_tc[v] = 0; end
          1: begin
            if (sel) m_mode[v] = 2;
            else if (fall) begin m_pc[v] = 0; m_tc[v] = 0; end
            else begin
              m_tc[v]++;
              if (rise) m_pc[v]++;
              if (m_pc[v] == PL || m_tc[v] == TO) begin m_mode[v] = 0; m_ptr[v] = 1'b1; end
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int v = 0; v < 2; v++) begin
        chk("R2 mode vs model", int'(mode[v]), m_mode[v]);
        chk("R8 ptr vs model", int'(ptr[v]), int'(m_ptr[v]));
        chk("R9 i2c flag", int'(i2c[v]), int'(m_mode[v] != 0));
      end
      if (ptr[0]) ptr_pulses++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic vpulse(input int n);
    repeat (n) begin vclk = 1'b1; cyc(3); vclk = 1'b0; cyc(3); end
  endtask
  task automatic scl_drop();
    scl = 1'b0; cyc(3); scl = 1'b1; cyc(3);
  endtask
  task automatic sel_pulse();
    sel = 1'b1; cyc(1); sel = 1'b0; cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int snap;
    cyc(3);
    chk("R1 reset mode", int'(mode[0]), 0);
    chk("R1 reset ptr", int'(ptr[0]), 1);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 ptr after release", int'(ptr[0]), 0);
    // R2: stream ignores vclk and sel
    vpulse(5); sel_pulse();
    chk("R2 stream holds", int'(mode[0]), 0);
    chk("R2 stream holds strict", int'(mode[1]), 0);
    scl_drop();
    chk("R2 enter probation", int'(mode[0]), 1);
    chk("R7 strict locks at once", int'(mode[1]), 2);
    chk("R9 i2c high", int'(i2c[0]), 1);
    // R3: pulse escape
    vpulse(PL - 1);
    chk("R3 before limit", int'(mode[0]), 1);
    snap = ptr_pulses;
    vpulse(1);
    chk("R3 limit returns", int'(mode[0]), 0);
    chk("R8 one ptr pulse", ptr_pulses - snap, 1);
    // R5: restart by SCL fall
    scl_drop(); vpulse(100); scl_drop(); vpulse(100);
    chk("R5 pulses restarted", int'(mode[0]), 1);
    cyc(TO - 800);
    chk("R5 timer restarted", int'(mode[0]), 1);
    snap = ptr_pulses;
    cyc(300);
    chk("R4 timeout returns", int'(mode[0]), 0);
    chk("R8 ptr after timeout", ptr_pulses - snap, 1);
    // R6: lock
    scl_drop(); sel_pulse();
    chk("R6 sel locks", int'(mode[0]), 2);
    vpulse(PL + 2); scl_drop(); cyc(TO + 100);
    chk("R6 locked sticky", int'(mode[0]), 2);
    chk("R7 strict sticky", int'(mode[1]), 2);
    // R7: only reset restores stream
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    chk("R7 reset restores", int'(mode[1]), 0);
    chk("R1 reset restores", int'(mode[0]), 0);
    scl_drop();
    chk("R7 relock", int'(mode[1]), 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule